// File: doc/BRIEF.md
# Multi-Field Video Timing Generator

This block generates the sync and data-enable timing for a parallel pixel output. A horizontal counter and a vertical counter walk every line and every field. The block drives horizontal sync, vertical sync and data enable, each with its own polarity. It also reports the current position and a tag for the kind of field being produced. Three operating modes are available: progressive, interlaced and stereo frame-packed. In the last two, consecutive fields take their vertical timing from different parameter sets.

Horizontal timing comes from four values: sync width, back porch, active width and front porch. These values are given in pixels. The `PPC` parameter divides them, so that one counter step covers `PPC` pixels. There are four vertical parameter sets, one for each field kind. Each set holds its own sync length, back porch, front porch and a half-line shift flag. All field kinds share one active line count. When the mode bits change, the soft-reset bit holds the generator idle, and the generator restarts from the first field when the bit is released.

Top module: `field_timing_gen`

## Requirements
- R1: Within each line, horizontal sync is active during the first `Hs` counts, where `Hs` is the scaled sync width. Counts run from x = 0.
- R2: A line is `Hs+Hb+Ha+Hf` counts long, made of sync, then back porch, then active, then front porch. `xOut` steps by one each cycle and wraps to 0 at the end of the line. When the sum is 0, the line is one count long.
- R3: Data enable is active only where both of these hold: `Hs+Hb <= x < Hs+Hb+Ha`, and `Vs+Vb <= y < Vs+Vb+cfgVActive`. `Vs` and `Vb` are the values of the current field's set.
- R4: A field is `Vs+Vb+cfgVActive+Vf` lines long. With the set's shift flag clear, vertical sync is active on lines `y < Vs`.
- R5: With the set's shift flag set and `Vs > 0`, both vertical sync edges move later by `floor(line length / 2)` counts. Vertical sync is then active from (y=0, x=half) up to, but not including, (y=Vs, x=half).
- R6: Field codes on `fieldOut` are as follows: bit 0 is set for an even field and bit 1 is set for a right-eye field (0 left odd, 1 left even, 2 right odd, 3 right even). The field order is:
  - progressive: 0 only;
  - interlace only: 0,1;
  - stereo only: 0,2;
  - both: 0,1,2,3.
- R7: Each field uses the vertical set whose code equals its field code. Set k sits at bits `[k*CNT_W +: CNT_W]` of `cfgVSync`, `cfgVBack` and `cfgVFront`, and at bit k of `cfgVHalf`.
- R8: Each of `cfgHsInv`, `cfgVsInv` and `cfgDeInv` inverts its own output when set to 1. `pclkInvOut` follows `cfgClkInv` one cycle later.
- R9: While `cfgSoftReset` is 1, the generator is idle. The first position output after release is x=0, y=0, field 0.
- R10: While `cfgEnable` is 0, the following hold:
  - hsync, vsync and data enable sit at their inactive level (the inversion bit);
  - the position outputs and field tag are 0;
  - re-enabling restarts at x=0, y=0, field 0.
- R11: With `PPC` = 4, each horizontal value is divided by 4, rounded down, before use.
- R12: While `rst_n` is low, every output is 0.
- Timing note: all outputs are registered together. hsync, vsync and data enable therefore describe the position shown on `xOut`, `yOut` and `fieldOut` in the same cycle. Each clock edge on which the generator runs emits the next position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Global enable |
| cfgSoftReset | input | 1 | Hold idle and restart at first field |
| cfgInterlace | input | 1 | Interlaced mode |
| cfgStereo | input | 1 | Frame-packed stereo mode |
| cfgHsInv | input | 1 | Invert hsync |
| cfgVsInv | input | 1 | Invert vsync |
| cfgDeInv | input | 1 | Invert data enable |
| cfgClkInv | input | 1 | Pixel clock inversion request |
| cfgHSync | input | CNT_W | Horizontal sync width, pixels |
| cfgHBack | input | CNT_W | Horizontal back porch, pixels |
| cfgHActive | input | CNT_W | Active width, pixels |
| cfgHFront | input | CNT_W | Horizontal front porch, pixels |
| cfgVActive | input | CNT_W | Active lines per field |
| cfgVSync | input | 4*CNT_W | Vertical sync lines, four sets |
| cfgVBack | input | 4*CNT_W | Vertical back porch, four sets |
| cfgVFront | input | 4*CNT_W | Vertical front porch, four sets |
| cfgVHalf | input | 4 | Half-line shift flag per set |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| pclkInvOut | output | 1 | Registered clock inversion level |
| xOut | output | CNT_W+2 | Horizontal position in counts |
| yOut | output | CNT_W+2 | Line within field |
| fieldOut | output | 2 | Field tag |

## Verification
The bench builds two copies of the block, both with `CNT_W` = 12. One has `PPC` = 1 and the other has `PPC` = 4, and both are driven from the same configuration pins. The back porch of 5 pixels scales to 1 count in the four-pixel copy, which puts the round-down of R11 within reach. Lines in the four-pixel copy are only 8 counts long, so that copy passes through many more fields and field wraps than the full-rate copy during the same scenario. The 33-count line of the full-rate copy gives an odd total, and its half-line shift rounds down to 16.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [1:0] {
    FLD_LODD  = 2'd0,
    FLD_LEVEN = 2'd1,
    FLD_RODD  = 2'd2,
    FLD_REVEN = 2'd3
  } fieldKind_e;

  // strobes from sequencing control to the output datapath
  typedef struct packed {
    logic       run;
    logic       halfShift;
    fieldKind_e field;
  } tgStrobe_t;

  function automatic fieldKind_e nextField(fieldKind_e cur, logic intl, logic stereo);
    fieldKind_e nxt;
    case (cur)
      FLD_LODD:  nxt = intl ? FLD_LEVEN : (stereo ? FLD_RODD : FLD_LODD);
      FLD_LEVEN: nxt = stereo ? FLD_RODD : FLD_LODD;
      FLD_RODD:  nxt = intl ? FLD_REVEN : FLD_LODD;
      default:   nxt = FLD_LODD;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/vtg_hscale.sv
module vtg_hscale #(
  parameter int W   = 12,
  parameter int PPC = 1
) (
  input  logic [W-1:0] valIn,
  output logic [W-1:0] valOut
);
  localparam int SHIFT = $clog2(PPC);

  generate
    if (PPC == 1) begin : g_pass
      assign valOut = valIn;
    end else begin : g_div
      assign valOut = valIn >> SHIFT;
    end
  endgenerate
endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int POS_W = CNT_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgEnable,
  input  logic               cfgSoftReset,
  input  logic               cfgInterlace,
  input  logic               cfgStereo,
  input  logic [POS_W-1:0]   hTot,
  input  logic [CNT_W-1:0]   vActive,
  input  logic [4*CNT_W-1:0] vSyncAll,
  input  logic [4*CNT_W-1:0] vBackAll,
  input  logic [4*CNT_W-1:0] vFrontAll,
  input  logic [3:0]         vHalfAll,
  output tgStrobe_t          stb,
  output logic [POS_W-1:0]   xPos,
  output logic [POS_W-1:0]   yPos,
  output logic [CNT_W-1:0]   vSyncCur,
  output logic [CNT_W-1:0]   vBackCur
);
  fieldKind_e field;
  logic run;
  logic lineWrap, fieldWrap;
  logic [CNT_W-1:0] vFrontCur;
  logic [POS_W-1:0] vTot;
  logic [POS_W:0] xNext, yNext;

  assign run       = cfgEnable & ~cfgSoftReset;
  assign vSyncCur  = vSyncAll[int'(field)*CNT_W +: CNT_W];
  assign vBackCur  = vBackAll[int'(field)*CNT_W +: CNT_W];
  assign vFrontCur = vFrontAll[int'(field)*CNT_W +: CNT_W];
  assign vTot      = POS_W'(vSyncCur) + POS_W'(vBackCur) + POS_W'(vActive) + POS_W'(vFrontCur);

  assign xNext     = {1'b0, xPos} + {{POS_W{1'b0}}, 1'b1};
  assign yNext     = {1'b0, yPos} + {{POS_W{1'b0}}, 1'b1};
  assign lineWrap  = xNext >= {1'b0, hTot};
  assign fieldWrap = lineWrap && (yNext >= {1'b0, vTot});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xPos  <= '0;
      yPos  <= '0;
      field <= FLD_LODD;
    end else if (!run) begin
      xPos  <= '0;
      yPos  <= '0;
      field <= FLD_LODD;
    end else if (lineWrap) begin
      xPos <= '0;
      if (fieldWrap) begin
        yPos  <= '0;
        field <= nextField(field, cfgInterlace, cfgStereo);
      end else begin
        yPos <= yNext[POS_W-1:0];
      end
    end else begin
      xPos <= xNext[POS_W-1:0];
    end
  end

  always_comb begin
    stb.run       = run;
    stb.halfShift = vHalfAll[int'(field)];
    stb.field     = field;
  end

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && xPos != '0) |-> xPos == $past(xPos) + POS_W'(1)); // R2

  AST_FIELD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && field != $past(field)) |-> $past(fieldWrap)); // R6

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> (xPos == '0 && yPos == '0 && field == FLD_LODD)); // R9
endmodule

// File: rtl/vtg_dpath.sv
module vtg_dpath
  import vtg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int POS_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tgStrobe_t        stb,
  input  logic [POS_W-1:0] xPos,
  input  logic [POS_W-1:0] yPos,
  input  logic [CNT_W-1:0] hSyncS,
  input  logic [CNT_W-1:0] hBackS,
  input  logic [CNT_W-1:0] hActS,
  input  logic [POS_W-1:0] hHalf,
  input  logic [CNT_W-1:0] vSyncCur,
  input  logic [CNT_W-1:0] vBackCur,
  input  logic [CNT_W-1:0] vActive,
  input  logic             hsInv,
  input  logic             vsInv,
  input  logic             deInv,
  input  logic             clkInv,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             deOut,
  output logic             pclkInvOut,
  output logic [POS_W-1:0] xOut,
  output logic [POS_W-1:0] yOut,
  output logic [1:0]       fieldOut
);
  logic [POS_W-1:0] deStartX, deEndX, deStartY, deEndY, vsW;
  logic hsNow, vsNow, deNow;
  logic hsAct, vsAct, deAct;
  logic hsInvQ, vsInvQ, deInvQ;

  assign vsW      = POS_W'(vSyncCur);
  assign deStartX = POS_W'(hSyncS) + POS_W'(hBackS);
  assign deEndX   = deStartX + POS_W'(hActS);
  assign deStartY = vsW + POS_W'(vBackCur);
  assign deEndY   = deStartY + POS_W'(vActive);

  always_comb begin
    hsNow = xPos < POS_W'(hSyncS);
    deNow = (xPos >= deStartX) && (xPos < deEndX) &&
            (yPos >= deStartY) && (yPos < deEndY);
    if (vsW == '0) begin
      vsNow = 1'b0;
    end else if (stb.halfShift) begin
      vsNow = (yPos == '0 && xPos >= hHalf) ||
              (yPos != '0 && yPos < vsW) ||
              (yPos == vsW && xPos < hHalf);
    end else begin
      vsNow = yPos < vsW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsAct <= 1'b0; vsAct <= 1'b0; deAct <= 1'b0;
      hsInvQ <= 1'b0; vsInvQ <= 1'b0; deInvQ <= 1'b0; pclkInvOut <= 1'b0;
      xOut <= '0; yOut <= '0; fieldOut <= '0;
    end else begin
      hsInvQ     <= hsInv;
      vsInvQ     <= vsInv;
      deInvQ     <= deInv;
      pclkInvOut <= clkInv;
      if (stb.run) begin
        hsAct    <= hsNow;
        vsAct    <= vsNow;
        deAct    <= deNow;
        xOut     <= xPos;
        yOut     <= yPos;
        fieldOut <= stb.field;
      end else begin
        hsAct <= 1'b0; vsAct <= 1'b0; deAct <= 1'b0;
        xOut <= '0; yOut <= '0; fieldOut <= '0;
      end
    end
  end

  assign hsyncOut = hsAct ^ hsInvQ;
  assign vsyncOut = vsAct ^ vsInvQ;
  assign deOut    = deAct ^ deInvQ;

  AST_DE_HS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    deAct |-> !hsAct); // R3

  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!stb.run) |-> (!hsAct && !vsAct && !deAct)); // R10

  AST_HS_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.run && xPos == '0 && hSyncS != '0) |=> hsAct); // R1
endmodule

// File: rtl/field_timing_gen.sv
module field_timing_gen
  import vtg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PPC   = 1,
  localparam int POS_W = CNT_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgEnable,
  input  logic               cfgSoftReset,
  input  logic               cfgInterlace,
  input  logic               cfgStereo,
  input  logic               cfgHsInv,
  input  logic               cfgVsInv,
  input  logic               cfgDeInv,
  input  logic               cfgClkInv,
  input  logic [CNT_W-1:0]   cfgHSync,
  input  logic [CNT_W-1:0]   cfgHBack,
  input  logic [CNT_W-1:0]   cfgHActive,
  input  logic [CNT_W-1:0]   cfgHFront,
  input  logic [CNT_W-1:0]   cfgVActive,
  input  logic [4*CNT_W-1:0] cfgVSync,
  input  logic [4*CNT_W-1:0] cfgVBack,
  input  logic [4*CNT_W-1:0] cfgVFront,
  input  logic [3:0]         cfgVHalf,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic               pclkInvOut,
  output logic [POS_W-1:0]   xOut,
  output logic [POS_W-1:0]   yOut,
  output logic [1:0]         fieldOut
);
  localparam int NUM_H = 4;

  logic [CNT_W-1:0] hRaw    [NUM_H];
  logic [CNT_W-1:0] hScaled [NUM_H];
  logic [POS_W-1:0] hTot, hHalf;
  logic [POS_W-1:0] xPos, yPos;
  logic [CNT_W-1:0] vSyncCur, vBackCur;
  tgStrobe_t stb;

  assign hRaw[0] = cfgHSync;
  assign hRaw[1] = cfgHBack;
  assign hRaw[2] = cfgHActive;
  assign hRaw[3] = cfgHFront;

  generate
    for (genvar i = 0; i < NUM_H; i++) begin : g_hs
      vtg_hscale #(.W(CNT_W), .PPC(PPC)) scale_i (
        .valIn (hRaw[i]),
        .valOut(hScaled[i])
      );
    end
  endgenerate

  assign hTot  = POS_W'(hScaled[0]) + POS_W'(hScaled[1]) + POS_W'(hScaled[2]) + POS_W'(hScaled[3]);
  assign hHalf = hTot >> 1;

  vtg_ctrl #(.CNT_W(CNT_W), .POS_W(POS_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cfgEnable(cfgEnable), .cfgSoftReset(cfgSoftReset),
    .cfgInterlace(cfgInterlace), .cfgStereo(cfgStereo),
    .hTot(hTot), .vActive(cfgVActive),
    .vSyncAll(cfgVSync), .vBackAll(cfgVBack), .vFrontAll(cfgVFront), .vHalfAll(cfgVHalf),
    .stb(stb), .xPos(xPos), .yPos(yPos),
    .vSyncCur(vSyncCur), .vBackCur(vBackCur)
  );

  vtg_dpath #(.CNT_W(CNT_W), .POS_W(POS_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .xPos(xPos), .yPos(yPos),
    .hSyncS(hScaled[0]), .hBackS(hScaled[1]), .hActS(hScaled[2]), .hHalf(hHalf),
    .vSyncCur(vSyncCur), .vBackCur(vBackCur), .vActive(cfgVActive),
    .hsInv(cfgHsInv), .vsInv(cfgVsInv), .deInv(cfgDeInv), .clkInv(cfgClkInv),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pclkInvOut(pclkInvOut),
    .xOut(xOut), .yOut(yOut), .fieldOut(fieldOut)
  );
endmodule

// File: tb/field_timing_gen_tb_top.sv
module field_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int PW = CW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, srst = 1'b0, intl = 1'b0, st = 1'b0;
  logic hsInv = 1'b0, vsInv = 1'b0, deInv = 1'b0, ckInv = 1'b0;
  logic [CW-1:0] hS, hB, hA, hF, vA;
  logic [4*CW-1:0] vS, vB, vF;
  logic [3:0] vH;

  logic hs1, vs1, de1, ck1, hs4, vs4, de4, ck4;
  logic [PW-1:0] x1, y1, x4, y4;
  logic [1:0] f1, f4;

  int checks = 0;
  int fails = 0;
  int mx[2], my[2], mf[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  field_timing_gen #(.CNT_W(CW), .PPC(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfgEnable(en), .cfgSoftReset(srst),
    .cfgInterlace(intl), .cfgStereo(st), .cfgHsInv(hsInv), .cfgVsInv(vsInv),
    .cfgDeInv(deInv), .cfgClkInv(ckInv), .cfgHSync(hS), .cfgHBack(hB),
    .cfgHActive(hA), .cfgHFront(hF), .cfgVActive(vA), .cfgVSync(vS),
    .cfgVBack(vB), .cfgVFront(vF), .cfgVHalf(vH),
    .hsyncOut(hs1), .vsyncOut(vs1), .deOut(de1), .pclkInvOut(ck1),
    .xOut(x1), .yOut(y1), .fieldOut(f1));

  field_timing_gen #(.CNT_W(CW), .PPC(4)) dut4_i (
    .clk(clk), .rst_n(rst_n), .cfgEnable(en), .cfgSoftReset(srst),
    .cfgInterlace(intl), .cfgStereo(st), .cfgHsInv(hsInv), .cfgVsInv(vsInv),
    .cfgDeInv(deInv), .cfgClkInv(ckInv), .cfgHSync(hS), .cfgHBack(hB),
    .cfgHActive(hA), .cfgHFront(hF), .cfgVActive(vA), .cfgVSync(vS),
    .cfgVBack(vB), .cfgVFront(vF), .cfgVHalf(vH),
    .hsyncOut(hs4), .vsyncOut(vs4), .deOut(de4), .pclkInvOut(ck4),
    .xOut(x4), .yOut(y4), .fieldOut(f4));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int setVal(logic [4*CW-1:0] v, int f);
    return int'(v[f*CW +: CW]);
  endfunction

  function automatic int nextF(int f);
    case (f)
      0: return intl ? 1 : (st ? 2 : 0);
      1: return st ? 2 : 0;
      2: return intl ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  // one clock: predict from the model at the edge, compare at the falling edge
  task automatic step(string rv, string rf);
    bit run;
    int ppc, hs_, hb_, ha_, hf_, hTot, half, f, vs_, vb_, vf_, vTot;
    int eh[2], ev[2], ed[2], ex[2], ey[2], ef[2];
    bit ha, va, da;
    @(posedge clk);
    run = en && !srst;
    for (int d = 0; d < 2; d++) begin
      if (!run) begin
        eh[d] = hsInv; ev[d] = vsInv; ed[d] = deInv;
        ex[d] = 0; ey[d] = 0; ef[d] = 0;
        mx[d] = 0; my[d] = 0; mf[d] = 0;
      end else begin
        ppc = (d == 1) ? 4 : 1;
        hs_ = int'(hS) / ppc; hb_ = int'(hB) / ppc;
        ha_ = int'(hA) / ppc; hf_ = int'(hF) / ppc;
        hTot = hs_ + hb_ + ha_ + hf_;
        half = hTot / 2;
        f = mf[d];
        vs_ = setVal(vS, f); vb_ = setVal(vB, f); vf_ = setVal(vF, f);
        vTot = vs_ + vb_ + int'(vA) + vf_;
        ha = mx[d] < hs_;
        da = (mx[d] >= hs_ + hb_) && (mx[d] < hs_ + hb_ + ha_) &&
             (my[d] >= vs_ + vb_) && (my[d] < vs_ + vb_ + int'(vA));
        if (vs_ == 0) va = 1'b0;
        else if (vH[f]) va = (my[d] == 0 && mx[d] >= half) || (my[d] != 0 && my[d] < vs_) ||
                             (my[d] == vs_ && mx[d] < half);
        else va = my[d] < vs_;
        eh[d] = ha ^ hsInv; ev[d] = va ^ vsInv; ed[d] = da ^ deInv;
        ex[d] = mx[d]; ey[d] = my[d]; ef[d] = f;
        if (mx[d] + 1 >= hTot) begin
          mx[d] = 0;
          if (my[d] + 1 >= vTot) begin my[d] = 0; mf[d] = nextF(f); end
          else my[d] = my[d] + 1;
        end else mx[d] = mx[d] + 1;
      end
    end
    @(negedge clk);
    chk(run ? "R1 hsync" : {rf, " hsync"}, int'(hs1), eh[0]);
    chk(run ? "R2 x" : {rf, " x"}, int'(x1), ex[0]);
    chk({rf, " y"}, int'(y1), ey[0]);
    chk(run ? "R3 de" : {rf, " de"}, int'(de1), ed[0]);
    chk({rv, " vsync"}, int'(vs1), ev[0]);
    chk({rf, " field"}, int'(f1), ef[0]);
    chk("R8 pclk", int'(ck1), int'(ckInv));
    chk("R11 hsync ppc4", int'(hs4), eh[1]);
    chk("R11 x ppc4", int'(x4), ex[1]);
    chk({rf, " y ppc4"}, int'(y4), ey[1]);
    chk("R11 de ppc4", int'(de4), ed[1]);
    chk({rv, " vsync ppc4"}, int'(vs4), ev[1]);
    chk({rf, " field ppc4"}, int'(f4), ef[1]);
  endtask

  task automatic runSteps(int n, string rv, string rf);
    for (int i = 0; i < n; i++) step(rv, rf);
  endtask

  task automatic restart(bit i, bit s);
    srst = 1'b1;
    step("R9", "R9");
    intl = i; st = s; en = 1'b1;
    srst = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R12 hsync", int'(hs1), 0);
    chk("R12 vsync", int'(vs1), 0);
    chk("R12 de", int'(de1), 0);
    chk("R12 x", int'(x1), 0);
    chk("R12 y", int'(y1), 0);
    chk("R12 field", int'(f1), 0);
    chk("R12 ppc4 x", int'(x4), 0);
    rst_n = 1'b1;
  endtask

  task automatic testProgressive();
    restart(1'b0, 1'b0);
    runSteps(360, "R4", "R6");
  endtask

  task automatic testInterlace();
    restart(1'b1, 1'b0);
    runSteps(420, "R5", "R7");
  endtask

  task automatic testStereo();
    restart(1'b0, 1'b1);
    runSteps(420, "R4", "R7");
  endtask

  task automatic testBoth();
    restart(1'b1, 1'b1);
    runSteps(800, "R5", "R6");
  endtask

  task automatic testPolarity();
    hsInv = 1'b1; vsInv = 1'b1; deInv = 1'b1; ckInv = 1'b1;
    runSteps(120, "R8", "R8");
    en = 1'b0;
    runSteps(10, "R10", "R10");
    en = 1'b1;
    runSteps(40, "R8", "R9");
    hsInv = 1'b0; vsInv = 1'b0; deInv = 1'b0; ckInv = 1'b0;
    runSteps(20, "R8", "R8");
  endtask

  task automatic testDisable();
    runSteps(50, "R5", "R6");
    en = 1'b0;
    runSteps(20, "R10", "R10");
    en = 1'b1;
    runSteps(80, "R5", "R10");
  endtask

  task automatic testSoftReset();
    runSteps(450, "R5", "R6");
    srst = 1'b1;
    runSteps(10, "R9", "R9");
    srst = 1'b0;
    runSteps(100, "R5", "R9");
  endtask

  initial begin
    hS = 12'd8; hB = 12'd5; hA = 12'd16; hF = 12'd4; vA = 12'd2;
    // sets 0..3: left odd, left even, right odd, right even
    vS = {12'd1, 12'd2, 12'd1, 12'd1};
    vB = {12'd2, 12'd1, 12'd1, 12'd1};
    vF = {12'd1, 12'd1, 12'd2, 12'd1};
    vH = 4'b1010;
    testReset();
    testProgressive();
    testInterlace();
    testStereo();
    testBoth();
    testPolarity();
    testDisable();
    testSoftReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule